// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous cycle controller in front of a small on-chip word array. Each word is split into byte lanes. On every rising clock edge it samples three chip enables, a processor-side and a controller-side address strobe, a burst advance input, and global, byte and per-lane write enables. From these it classifies the cycle as idle, deselect, begin read, begin write, continue (read or write) or suspend (read or write).

Write data is stored into the selected lanes on the edge that classifies the cycle as a write. Read data for an address registered on one edge is loaded into an output register on the following edge. An output-drive flag tells the surrounding pad logic when to drive the data bus. This flag follows a double-cycle deselect, is forced off after any write cycle, and is gated combinationally by an active-low output enable.

Bursts step through the low two address bits with a linear wrap. The upper address bits stay fixed during a burst.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While the master enable `ce0_ni` is high, a low `adsp_ni` has no effect. If `adsc_ni` is low while `ce0_ni` is high, the cycle is a deselect.
- R2: `adsp_ni` low with `ce0_ni` low, `ce1_i` high and `ce2_ni` low begins a read at `addr_i`. This holds whatever `adsc_ni` and all write enables show, so lane enables on that edge neither write nor turn the bus off.
- R3: `adsc_ni` low with `adsp_ni` high and all chip enables active begins a cycle at `addr_i`. The write enables on that edge choose between a write and a read.
- R4: If a strobe starts a cycle with `ce0_ni` low but `ce1_i` low or `ce2_ni` high, the cycle is a deselect. Nothing is written and no read is scheduled.
- R5: A cycle is a write when `gwe_ni` is low, and then both lanes are written. It is also a write when `gwe_ni` is high, `bwe_ni` is low and some `bw_ni` bit is low, and then only those lanes are written. Bit 0 selects data bits 8:0 and bit 1 selects bits 17:9. Any other combination is a read.
- R6: When both strobes are high during an active burst, `adv_ni` low moves to the next address and `adv_ni` high stays at the current address. The next address is the low two bits plus one, modulo 4, with the upper bits kept. The write enables on that edge give the cycle its type. After reset or a deselect, such cycles do nothing.
- R7: For a read whose address is registered on edge k, the word is presented on `rdata_o` with `drive_o` high after edge k+1.
- R8: In the cycle after any write cycle, `drive_o` is low whatever `oe_ni` shows.
- R9: `drive_o` is low at once whenever `oe_ni` is high, with no clock edge needed.
- R10: If a read is pending when a deselect is sampled on edge k, its data is still driven after edge k. `drive_o` falls after edge k+1.
- R11: After reset, `drive_o` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (6) | Word address, loaded when a cycle begins |
| ce0_ni | input | 1 | Master chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| adsp_ni | input | 1 | Processor-side address strobe, active low |
| adsc_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwe_ni | input | 1 | Global write enable, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | LANES (2) | Per-lane write enables, active low |
| oe_ni | input | 1 | Output enable, active low, not registered |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Registered read data |
| drive_o | output | 1 | High when the data bus is to be driven |

## Verification
The embedded assertions check several rules on every clock:
- the master enable blocks the processor strobe and turns a controller-strobe cycle into a deselect;
- a qualified processor strobe always decodes to a read;
- a decoded write always names at least one lane;
- the bus is off after any write;
- a rising drive flag always follows a pending read;
- a deselect never schedules a read.

Only the bench's scenarios can show the data that comes back from the array. These include partial-lane merges, the wrap of a four-beat burst, a suspend holding its address, the data still driven in the cycle after a deselect, and the immediate effect of the output enable between clock edges.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
  typedef enum logic [2:0] {
    CY_IDLE, CY_DESEL, CY_BEG_RD, CY_BEG_WR,
    CY_CONT_RD, CY_CONT_WR, CY_SUSP_RD, CY_SUSP_WR
  } cyc_e;

  function automatic logic cyc_is_wr(cyc_e c);
    return (c == CY_BEG_WR) || (c == CY_CONT_WR) || (c == CY_SUSP_WR);
  endfunction

  function automatic logic cyc_is_rd(cyc_e c);
    return (c == CY_BEG_RD) || (c == CY_CONT_RD) || (c == CY_SUSP_RD);
  endfunction

  function automatic logic cyc_is_beg(cyc_e c);
    return (c == CY_BEG_RD) || (c == CY_BEG_WR);
  endfunction

  function automatic logic cyc_is_cont(cyc_e c);
    return (c == CY_CONT_RD) || (c == CY_CONT_WR);
  endfunction
endpackage

// File: rtl/sbc_decode.sv
`timescale 1ns/1ps
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce0_ni,
  input  logic             ce1_i,
  input  logic             ce2_ni,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             gwe_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             active_i,
  output cyc_e             cyc_o,
  output logic [LANES-1:0] lanes_o
);
  logic sel_ok;
  logic wr_req;

  assign sel_ok = ce1_i && !ce2_ni;

  always_comb begin
    if (!gwe_ni)      lanes_o = '1;
    else if (!bwe_ni) lanes_o = ~bw_ni;
    else              lanes_o = '0;
  end

  assign wr_req = |lanes_o;

  always_comb begin
    cyc_o = CY_IDLE;
    if (!adsp_ni && !ce0_ni) begin
      // processor strobe: always a read, lane enables ignored
      cyc_o = sel_ok ? CY_BEG_RD : CY_DESEL;
    end else if (!adsc_ni) begin
      if (!ce0_ni && sel_ok) cyc_o = wr_req ? CY_BEG_WR : CY_BEG_RD;
      else                   cyc_o = CY_DESEL;
    end else if (active_i) begin
      if (!adv_ni) cyc_o = wr_req ? CY_CONT_WR : CY_CONT_RD;
      else         cyc_o = wr_req ? CY_SUSP_WR : CY_SUSP_RD;
    end
  end
endmodule

// File: rtl/sbc_burst_addr.sv
`timescale 1ns/1ps
module sbc_burst_addr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << BURST_W) - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] nxt;

  // linear wrap inside the burst window
  assign nxt = (addr_q & ~LOW_MASK) | ((addr_q + ADDR_W'(1)) & LOW_MASK);

  always_comb begin
    if (load_i)      eff_o = addr_i;
    else if (step_i) eff_o = nxt;
    else             eff_o = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= eff_o;
  end

  assign addr_q_o = addr_q;

  AST_STEP_KEEPS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ((addr_q & ~LOW_MASK) == $past(addr_q & ~LOW_MASK))); // R6
endmodule

// File: rtl/sbc_array.sv
`timescale 1ns/1ps
module sbc_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (re_i)    rd_q <= mem[raddr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sbc_out.sv
`timescale 1ns/1ps
module sbc_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_pend_i,
  input  logic wr_now_i,
  input  logic oe_ni,
  output logic drive_o
);
  logic drv_q;

  // registered pending read gives the extra deselect cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= rd_pend_i && !wr_now_i;
  end

  assign drive_o = drv_q && !oe_ni;

  AST_WRITE_FORCES_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_now_i |=> !drive_o); // R8
  AST_DRIVE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $past(rd_pend_i)); // R7
endmodule

// File: rtl/sram_burst_ctrl.sv
`timescale 1ns/1ps
module sram_burst_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ce2_ni,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  cyc_e              cyc;
  logic [LANES-1:0]  lanes;
  logic              active_q;
  logic              rd_pend_q;
  logic              is_wr;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_q;

  sbc_decode #(.LANES(LANES)) u_dec (
    .ce0_ni  (ce0_ni),
    .ce1_i   (ce1_i),
    .ce2_ni  (ce2_ni),
    .adsp_ni (adsp_ni),
    .adsc_ni (adsc_ni),
    .adv_ni  (adv_ni),
    .gwe_ni  (gwe_ni),
    .bwe_ni  (bwe_ni),
    .bw_ni   (bw_ni),
    .active_i(active_q),
    .cyc_o   (cyc),
    .lanes_o (lanes)
  );

  assign is_wr = cyc_is_wr(cyc);

  sbc_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cyc_is_beg(cyc)),
    .step_i  (cyc_is_cont(cyc)),
    .addr_i  (addr_i),
    .eff_o   (eff_addr),
    .addr_q_o(addr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      if (cyc_is_beg(cyc))     active_q <= 1'b1;
      else if (cyc == CY_DESEL) active_q <= 1'b0;
      rd_pend_q <= cyc_is_rd(cyc);
    end
  end

  sbc_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk_i  (clk_i),
    .we_i   (is_wr ? lanes : '0),
    .waddr_i(eff_addr),
    .wdata_i(wdata_i),
    .re_i   (rd_pend_q),
    .raddr_i(addr_q),
    .rdata_o(rdata_o)
  );

  sbc_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_pend_i(rd_pend_q),
    .wr_now_i (is_wr),
    .oe_ni    (oe_ni),
    .drive_o  (drive_o)
  );

  AST_CE0_BLOCKS_ADSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce0_ni && !adsc_ni) |-> (cyc == CY_DESEL)); // R1
  AST_ADSP_ALWAYS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce0_ni && ce1_i && !ce2_ni) |-> (cyc == CY_BEG_RD)); // R2
  AST_BAD_CE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce0_ni && (!adsp_ni || !adsc_ni) && (!ce1_i || ce2_ni)) |-> (cyc == CY_DESEL)); // R4
  AST_WRITE_HAS_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |-> (lanes != '0)); // R5
  AST_DESEL_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CY_DESEL) |=> !rd_pend_q); // R10
endmodule

// File: tb/sim_sram_burst_ctrl.sv
`timescale 1ns/1ps
module sim_sram_burst_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0] addr_i = '0;
  logic ce0_ni = 1'b1, ce1_i = 1'b0, ce2_ni = 1'b1;
  logic adsp_ni = 1'b1, adsc_ni = 1'b1, adv_ni = 1'b1;
  logic gwe_ni = 1'b1, bwe_ni = 1'b1, oe_ni = 1'b0;
  logic [1:0] bw_ni = 2'b11;
  logic [17:0] wdata_i = '0;
  logic [17:0] rdata_o;
  logic drive_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sram_burst_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .ce0_ni(ce0_ni), .ce1_i(ce1_i),
    .ce2_ni(ce2_ni), .adsp_ni(adsp_ni), .adsc_ni(adsc_ni), .adv_ni(adv_ni),
    .gwe_ni(gwe_ni), .bwe_ni(bwe_ni), .bw_ni(bw_ni), .oe_ni(oe_ni),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  typedef struct {
    logic        drv;
    logic [17:0] data;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [17:0] m_mem [64];
  logic        m_active = 1'b0;
  logic        m_rpend  = 1'b0;
  logic [5:0]  m_addr   = '0;
  logic [17:0] m_rdata  = '0;

  task automatic check(input logic ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(drive_o === e.drv, {e.tag, " drive"}, {17'd0, drive_o}, {17'd0, e.drv});
      if (e.drv) check(rdata_o === e.data, {e.tag, " data"}, rdata_o, e.data);
    end
  end

  task automatic cyc(input logic ce0, input logic ce1, input logic ce2,
                     input logic adsp, input logic adsc, input logic adv,
                     input logic gwe, input logic bwe, input logic [1:0] bw,
                     input logic oe, input logic [5:0] a, input logic [17:0] d,
                     input string tag);
    logic beg, cont, desel, idle, wr;
    logic [1:0] ln;
    logic [5:0] eff;
    logic [17:0] nrd;
    logic ndrv;
    exp_t e;
    @(negedge clk);
    ce0_ni = ce0; ce1_i = ce1; ce2_ni = ce2; adsp_ni = adsp; adsc_ni = adsc;
    adv_ni = adv; gwe_ni = gwe; bwe_ni = bwe; bw_ni = bw; oe_ni = oe;
    addr_i = a; wdata_i = d;
    ln = !gwe ? 2'b11 : (!bwe ? ~bw : 2'b00);
    beg = 0; cont = 0; desel = 0; idle = 0; wr = 0;
    if (!adsp && !ce0) begin
      if (ce1 && !ce2) beg = 1; else desel = 1;
    end else if (!adsc) begin
      if (!ce0 && ce1 && !ce2) begin beg = 1; wr = (ln != 0); end
      else desel = 1;
    end else if (!m_active) idle = 1;
    else begin cont = !adv; wr = (ln != 0); end
    nrd  = m_rpend ? m_mem[m_addr] : m_rdata;
    ndrv = m_rpend && !wr;
    eff  = beg ? a : (cont ? {m_addr[5:2], m_addr[1:0] + 2'd1} : m_addr);
    if (wr) begin
      if (ln[0]) m_mem[eff][8:0]  = d[8:0];
      if (ln[1]) m_mem[eff][17:9] = d[17:9];
    end
    if (!desel && !idle) m_addr = eff;
    if (beg) m_active = 1; else if (desel) m_active = 0;
    m_rpend = !desel && !idle && !wr;
    m_rdata = nrd;
    e.drv = ndrv && !oe; e.data = nrd; e.tag = tag;
    q.push_back(e);
  endtask

  // shorthands
  task automatic wr_c(input logic [5:0] a, input logic [17:0] d, input logic gwe,
                      input logic bwe, input logic [1:0] bw, input string tag);
    cyc(0, 1, 0, 1, 0, 1, gwe, bwe, bw, 0, a, d, tag);
  endtask
  task automatic rd_p(input logic [5:0] a, input string tag);
    cyc(0, 1, 0, 0, 1, 1, 0, 0, 2'b00, 0, a, 18'h0, tag);  // enables low: must be ignored
  endtask
  task automatic step(input logic adv, input logic wr, input logic [17:0] d, input string tag);
    cyc(0, 1, 0, 1, 1, adv, !wr, 1, 2'b11, 0, 6'h3f, d, tag);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    n_fail++;
    $display("FAIL R11 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(drive_o === 1'b0, "R11 reset drive", {17'd0, drive_o}, 18'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R11: strobeless cycles before any begin do nothing
    step(1, 1, 18'h3ffff, "R11 idle");
    step(0, 0, 18'h0, "R11 idle");

    // R3 R5: controller-strobe writes, full and partial
    wr_c(6'd4, 18'h1a5a5, 0, 1, 2'b11, "R3 full write");
    wr_c(6'd5, 18'h3ffff, 0, 1, 2'b11, "R5 full write");
    wr_c(6'd5, 18'h00055, 1, 0, 2'b10, "R5 lane0 write");
    wr_c(6'd6, 18'h2aaaa, 1, 0, 2'b11, "R5 no lane -> read");
    wr_c(6'd7, 18'h12345, 1, 0, 2'b01, "R5 lane1 write");
    // R2 R7: processor-strobe reads with write enables low
    rd_p(6'd4, "R2 read begin");
    rd_p(6'd5, "R7 read data");
    step(1, 0, 18'h0, "R7 suspend read");
    rd_p(6'd7, "R7 read data");
    step(1, 0, 18'h0, "R7 read data");

    // R6: burst write with wrap, then burst read
    wr_c(6'd9, 18'h00001, 0, 1, 2'b11, "R6 burst write");
    step(0, 1, 18'h00002, "R6 cont write");
    step(0, 1, 18'h00003, "R6 cont write");
    step(1, 1, 18'h00033, "R6 suspend write");
    step(0, 1, 18'h00004, "R6 wrap write");
    rd_p(6'd10, "R6 burst read");
    step(0, 0, 18'h0, "R6 cont read");
    step(1, 0, 18'h0, "R6 suspend read");
    step(0, 0, 18'h0, "R6 wrap read");
    step(0, 0, 18'h0, "R6 wrap read");
    step(0, 0, 18'h0, "R6 cont read");

    // R1: ce0 high blocks adsp -> suspend at current address
    rd_p(6'd4, "R1 read");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 2'b11, 0, 6'd9, 18'h0, "R1 adsp blocked");
    step(1, 0, 18'h0, "R1 adsp blocked");
    // R1 R10: ce0 high with adsc -> deselect, data held one more cycle
    cyc(1, 0, 1, 1, 0, 1, 0, 1, 2'b11, 0, 6'd5, 18'h0, "R10 desel");
    step(0, 1, 18'h3ffff, "R10 off after desel");
    step(1, 0, 18'h0, "R1 inactive");
    rd_p(6'd4, "R1 no write to 4");
    step(1, 0, 18'h0, "R1 no write to 4");

    // R4: bad secondary enables -> deselect
    cyc(0, 0, 0, 0, 1, 1, 1, 1, 2'b11, 0, 6'd5, 18'h0, "R4 ce1 low");
    step(1, 0, 18'h0, "R4 desel hold");
    cyc(0, 1, 1, 1, 0, 1, 0, 1, 2'b11, 0, 6'd4, 18'h0bad0, "R4 ce2 high");
    step(1, 0, 18'h0, "R4 inactive");
    rd_p(6'd4, "R4 no write");
    step(1, 0, 18'h0, "R4 no write");

    // R8: read then lane write to same address -> bus off
    rd_p(6'd12, "R8 read begin");
    cyc(0, 1, 0, 1, 1, 1, 1, 0, 2'b01, 0, 6'h3f, 18'h2f000, "R8 write hiz");
    step(1, 0, 18'h0, "R8 after write");
    step(1, 0, 18'h0, "R8 readback");

    // R9: output enable high
    rd_p(6'd4, "R9 read");
    cyc(0, 1, 0, 1, 1, 1, 1, 1, 2'b11, 1, 6'h3f, 18'h0, "R9 oe high");
    step(1, 0, 18'h0, "R9 oe low");
    @(posedge clk);
    #1.5;
    oe_ni = 1'b1;
    #0.2;
    check(drive_o === 1'b0, "R9 oe async off", {17'd0, drive_o}, 18'd0);
    oe_ni = 1'b0;
    #0.2;
    check(drive_o === 1'b1, "R9 oe async on", {17'd0, drive_o}, 18'd1);
    step(1, 0, 18'h0, "R9 hold");
    cyc(0, 0, 0, 1, 0, 1, 1, 1, 2'b11, 0, 6'd0, 18'h0, "R10 desel");
    step(1, 0, 18'h0, "R10 off");
    repeat (3) @(posedge clk);
    #1.8;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule